// File: doc/BRIEF.md
# Byte-Written Scratch Register Bridge With Display Interrupt

This block sits inside an audio codec and holds two 32-bit scratch registers that a host reaches through vendor-defined command verbs. Each command carries a codec address, a node ID, a 12-bit verb and an 8-bit payload. Read verbs return a whole register. Write verbs change a single byte. Every accepted command is answered with one 32-bit response, one cycle after it arrives.

The first register tells a paired display engine about the audio format. Bit 31 is a trigger, bit 30 is a valid flag (0 means the format is invalid and audio must be disabled, 1 means the format may be used), bits 29:16 are spare and bits 15:0 hold the format word. The display side is told of a change by a one-cycle interrupt pulse. A static configuration input picks how that pulse is produced. In legacy mode a byte write that flips the trigger bit raises it. In newer mode a dedicated interrupt verb raises it. The two modes also answer at different nodes.

Top module: `verb_scratch_bridge`

## Requirements
- R1: Each cycle with `cmd_valid` high produces exactly one cycle of `rsp_valid` on the next cycle. `rsp_valid` stays low after idle cycles. `rsp_data` is zero whenever `rsp_valid` is low.
- R2: Verb 0xFA6 returns the whole of scratch register 0 and verb 0xFAB returns the whole of scratch register 1, in both cases the value held before the command.
- R3: Verbs 0xFA7, 0xFA8, 0xFA9 and 0xFAA write the payload into byte 0, 1, 2 and 3 (bits 7:0 up to 31:24) of register 0. Verbs 0xFAC to 0xFAF do the same for register 1. The other bytes are kept. A write answers with zero.
- R4: A command is accepted only when its codec address equals `CODEC_ADDR` (default 0) and its node ID equals 0x01 in legacy mode or `CONV_NID` (default 0x04) in newer mode. Any other command answers zero, changes no register and raises no interrupt.
- R5: In legacy mode (`mode_new`=0), a write of byte 3 of register 0 whose payload bit 7 differs from the current bit 31 raises `irq_pulse` for one cycle, in the same cycle as its response. A write that keeps bit 31, and any write to register 1, raises nothing.
- R6: In newer mode (`mode_new`=1), changing bit 31 raises no interrupt. Verb 0xF80 with a nonzero payload raises `irq_pulse` for one cycle, in the same cycle as its response. With a zero payload it raises nothing. Verb 0xF80 answers zero.
- R7: In legacy mode, verb 0xF80 is ignored entirely: it answers zero, raises no interrupt and changes no register.
- R8: Any other verb answers zero and changes no register.
- R9: While reset is asserted, both registers clear to zero, and `rsp_valid` and `irq_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_new | input | 1 | 0 selects legacy trigger-bit mode, 1 selects interrupt-verb mode (static) |
| cmd_valid | input | 1 | Command strobe |
| cmd_cad | input | 4 | Codec address of the command |
| cmd_nid | input | 8 | Node ID of the command |
| cmd_verb | input | 12 | Verb code |
| cmd_data | input | 8 | Verb payload |
| rsp_valid | output | 1 | Response strobe, one cycle after the command |
| rsp_data | output | 32 | Response word |
| irq_pulse | output | 1 | One-cycle interrupt toward the display engine |

## Verification
The bench targets the legacy trigger: rewriting bit 31 with its own value must stay silent, while flipping it in either direction must pulse. A design that decodes a level, or any write to byte 3, would pulse on every write. A write to byte 3 of register 1 with bit 7 set checks that the trigger is tied to register 0 only. The interrupt verb is exercised with a zero payload, with a nonzero payload, and in legacy mode, where it must be silent. Commands with the other mode's node ID or a foreign codec address are sent, and a read after them exposes any leak into the registers. Read-after-byte-write sequences catch lane swaps and lost neighbouring bytes.

// File: rtl/svb_pkg.sv
package svb_pkg;

    localparam int DATA_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int NBYTES      = DATA_W / BYTE_W;
    localparam int NUM_REGS    = 2;
    localparam int VERB_W      = 12;
    localparam int NID_W       = 8;
    localparam int CAD_W       = 4;
    localparam int REG_IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int BYTE_IDX_W  = $clog2(NBYTES);

    // read verb of register r is REG_VERB_BASE + r*REG_VERB_STRIDE,
    // byte-write verbs follow it in byte order
    localparam int REG_VERB_BASE   = 'hFA6;
    localparam int REG_VERB_STRIDE = NBYTES + 1;
    localparam logic [VERB_W-1:0] VERB_HOST_IRQ = 12'hF80;

    localparam int TRIG_BIT  = DATA_W - 1;
    localparam int TRIG_BYTE = NBYTES - 1;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_IRQ
    } op_e;

    typedef struct packed {
        logic [CAD_W-1:0]  cad;
        logic [NID_W-1:0]  nid;
        logic [VERB_W-1:0] verb;
        logic [BYTE_W-1:0] payload;
    } cmd_t;

    typedef struct packed {
        op_e                   op;
        logic [REG_IDX_W-1:0]  reg_idx;
        logic [BYTE_IDX_W-1:0] byte_idx;
    } dec_t;

    function automatic dec_t decode_verb(input logic [VERB_W-1:0] verb);
        dec_t d;
        d = '{op: OP_NONE, reg_idx: '0, byte_idx: '0};
        if (verb == VERB_HOST_IRQ) begin
            d.op = OP_IRQ;
        end
        for (int r = 0; r < NUM_REGS; r++) begin
            if (verb == VERB_W'(REG_VERB_BASE + r * REG_VERB_STRIDE)) begin
                d.op      = OP_READ;
                d.reg_idx = REG_IDX_W'(r);
            end
            for (int b = 0; b < NBYTES; b++) begin
                if (verb == VERB_W'(REG_VERB_BASE + r * REG_VERB_STRIDE + 1 + b)) begin
                    d.op       = OP_WRITE;
                    d.reg_idx  = REG_IDX_W'(r);
                    d.byte_idx = BYTE_IDX_W'(b);
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/svb_decode.sv
module svb_decode
    import svb_pkg::*;
#(
    parameter logic [CAD_W-1:0] CODEC_ADDR = '0,
    parameter logic [NID_W-1:0] LEG_NID    = 8'h01,
    parameter logic [NID_W-1:0] CONV_NID   = 8'h04
) (
    input  logic cmd_valid,
    input  cmd_t cmd,
    input  logic mode_new,
    output dec_t dec
);

    logic [NID_W-1:0] own_nid;
    logic             hit;
    dec_t             raw;

    assign own_nid = mode_new ? CONV_NID : LEG_NID;
    assign hit     = cmd_valid && (cmd.cad == CODEC_ADDR) && (cmd.nid == own_nid);
    assign raw     = decode_verb(cmd.verb);

    always_comb begin
        dec = raw;
        if (!hit) begin
            dec.op = OP_NONE;
        end else if (raw.op == OP_IRQ && (!mode_new || cmd.payload == '0)) begin
            dec.op = OP_NONE;
        end
    end

endmodule

// File: rtl/svb_scratch.sv
module svb_scratch
    import svb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [BYTE_IDX_W-1:0] byte_idx,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [DATA_W-1:0]     q
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                q[b*BYTE_W +: BYTE_W] <= '0;
            end else if (wr_en && byte_idx == BYTE_IDX_W'(b)) begin
                q[b*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/svb_irq.sv
module svb_irq
    import svb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_new,
    input  logic trig_wr,
    input  logic new_trig,
    input  logic cur_trig,
    input  logic irq_verb,
    output logic irq_pulse
);

    logic fire;

    assign fire = mode_new ? irq_verb : (trig_wr && (new_trig != cur_trig));

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= fire;
        end
    end

endmodule

// File: rtl/verb_scratch_bridge.sv
module verb_scratch_bridge
    import svb_pkg::*;
#(
    parameter logic [CAD_W-1:0] CODEC_ADDR = '0,
    parameter logic [NID_W-1:0] LEG_NID    = 8'h01,
    parameter logic [NID_W-1:0] CONV_NID   = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_new,
    input  logic              cmd_valid,
    input  logic [CAD_W-1:0]  cmd_cad,
    input  logic [NID_W-1:0]  cmd_nid,
    input  logic [VERB_W-1:0] cmd_verb,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              irq_pulse
);

    cmd_t              cmd;
    dec_t              dec;
    logic [DATA_W-1:0] reg_q [NUM_REGS];
    logic [DATA_W-1:0] rsp_next;
    logic [DATA_W-1:0] scr0_q;
    logic [DATA_W-1:0] scr1_q;
    logic              trig_wr;

    assign cmd = '{cad: cmd_cad, nid: cmd_nid, verb: cmd_verb, payload: cmd_data};

    svb_decode #(
        .CODEC_ADDR (CODEC_ADDR),
        .LEG_NID    (LEG_NID),
        .CONV_NID   (CONV_NID)
    ) i_decode (
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .mode_new  (mode_new),
        .dec       (dec)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        svb_scratch i_scratch (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (dec.op == OP_WRITE && dec.reg_idx == REG_IDX_W'(r)),
            .byte_idx (dec.byte_idx),
            .wdata    (cmd_data),
            .q        (reg_q[r])
        );
    end

    assign scr0_q  = reg_q[0];
    assign scr1_q  = reg_q[1];
    assign trig_wr = (dec.op == OP_WRITE) && (dec.reg_idx == '0)
                     && (dec.byte_idx == BYTE_IDX_W'(TRIG_BYTE));

    svb_irq i_irq (
        .clk       (clk),
        .rst       (rst),
        .mode_new  (mode_new),
        .trig_wr   (trig_wr),
        .new_trig  (cmd_data[BYTE_W-1]),
        .cur_trig  (scr0_q[TRIG_BIT]),
        .irq_verb  (dec.op == OP_IRQ),
        .irq_pulse (irq_pulse)
    );

    assign rsp_next = (dec.op == OP_READ) ? reg_q[dec.reg_idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_data  <= rsp_next;
        end
    end

endmodule

// File: rtl/svb_checker.sv
module svb_checker
    import svb_pkg::*;
#(
    parameter logic [CAD_W-1:0] CODEC_ADDR = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_new,
    input logic              cmd_valid,
    input logic [CAD_W-1:0]  cmd_cad,
    input logic [VERB_W-1:0] cmd_verb,
    input logic [BYTE_W-1:0] cmd_data,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              irq_pulse,
    input logic [DATA_W-1:0] scr0,
    input logic [DATA_W-1:0] scr1
);

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid); // R1
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid); // R1
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> rsp_data == '0); // R1
    AST_MISS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_cad != CODEC_ADDR) |=>
        (rsp_data == '0 && !irq_pulse && $stable(scr0) && $stable(scr1))); // R4
    AST_IRQ_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(cmd_valid)); // R5
    AST_LEG_TRIG_FLIP: assert property (@(posedge clk) disable iff (rst)
        (!mode_new && irq_pulse) |-> (scr0[TRIG_BIT] != $past(scr0[TRIG_BIT]))); // R5
    AST_NEW_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode_new && cmd_valid && cmd_verb == VERB_HOST_IRQ && cmd_data == '0)
        |=> !irq_pulse); // R6
    AST_LEG_IRQ_VERB_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!mode_new && cmd_valid && cmd_verb == VERB_HOST_IRQ) |=>
        (!irq_pulse && rsp_data == '0 && $stable(scr0) && $stable(scr1))); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (scr0 == '0 && scr1 == '0 && !irq_pulse && !rsp_valid)); // R9

endmodule

bind verb_scratch_bridge svb_checker #(.CODEC_ADDR(CODEC_ADDR)) i_svb_checker (
    .clk       (clk),
    .rst       (rst),
    .mode_new  (mode_new),
    .cmd_valid (cmd_valid),
    .cmd_cad   (cmd_cad),
    .cmd_verb  (cmd_verb),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .irq_pulse (irq_pulse),
    .scr0      (scr0_q),
    .scr1      (scr1_q)
);

// File: tb/test_verb_scratch_bridge.sv
`timescale 1ns/1ps
module test_verb_scratch_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_new = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_cad = '0;
    logic [7:0]  cmd_nid = '0;
    logic [11:0] cmd_verb = '0;
    logic [7:0]  cmd_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        irq_pulse;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_reg [2];
    int seed_dummy;

    always #2 clk = ~clk;

    verb_scratch_bridge i_verb_scratch_bridge (
        .clk(clk), .rst(rst), .mode_new(mode_new), .cmd_valid(cmd_valid),
        .cmd_cad(cmd_cad), .cmd_nid(cmd_nid), .cmd_verb(cmd_verb), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_pulse(irq_pulse)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic new_mode);
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b0;
        mode_new = new_mode;
        m_reg[0] = '0;
        m_reg[1] = '0;
        repeat (3) @(negedge clk);
        check("R9", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R9", "irq in reset", {31'd0, irq_pulse}, 32'd0);
        rst = 1'b0;
    endtask

    // drive at a falling edge, check after the next rising edge
    task automatic send(input logic [3:0] cad, input logic [7:0] nid, input logic [11:0] verb, input logic [7:0] data);
        logic [31:0] ersp;
        logic        eirq;
        string       tag;
        string       itag;
        logic        hit;
        ersp = '0;
        eirq = 1'b0;
        tag  = "R8";
        itag = mode_new ? "R6" : "R5";
        hit  = (cad == 4'd0) && (nid == (mode_new ? 8'h04 : 8'h01));
        if (!hit) begin
            tag = "R4";
        end else if (verb == 12'hF80) begin
            tag  = mode_new ? "R6" : "R7";
            itag = tag;
            eirq = mode_new && (data != 8'd0);
        end else begin
            for (int r = 0; r < 2; r++) begin
                if (verb == 12'(12'hFA6 + 5*r)) begin
                    tag = "R2";
                    ersp = m_reg[r];
                end
                for (int b = 0; b < 4; b++) begin
                    if (verb == 12'(12'hFA7 + 5*r + b)) begin
                        tag = "R3";
                        if (!mode_new && r == 0 && b == 3 && data[7] != m_reg[0][31]) eirq = 1'b1;
                        m_reg[r][8*b +: 8] = data;
                    end
                end
            end
        end
        cmd_cad = cad; cmd_nid = nid; cmd_verb = verb; cmd_data = data;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check(tag, "rsp_data", rsp_data, ersp);
        check(itag, "irq_pulse", {31'd0, irq_pulse}, {31'd0, eirq});
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R1", "rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
        check("R1", "rsp_data idle", rsp_data, 32'd0);
    endtask

    task automatic random_run(input int n);
        logic [11:0] verb;
        logic [7:0]  nid;
        logic [3:0]  cad;
        int          k;
        logic [7:0]  own;
        own = mode_new ? 8'h04 : 8'h01;
        for (int i = 0; i < n; i++) begin
            k = $urandom % 14;
            if (k < 10)       verb = 12'(12'hFA6 + k);
            else if (k < 12)  verb = 12'hF80;
            else              verb = 12'($urandom);
            nid = ($urandom % 8 == 0) ? 8'($urandom) : own;
            cad = ($urandom % 10 == 0) ? 4'($urandom) : 4'd0;
            send(cad, nid, verb, 8'($urandom));
            if ($urandom % 5 == 0) idle_check();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5EED_0042);
        // ---------------- legacy mode ----------------
        do_reset(1'b0);
        send(4'd0, 8'h01, 12'hFA6, 8'h00);   // R9 register 0 cleared
        send(4'd0, 8'h01, 12'hFAB, 8'h00);   // R9 register 1 cleared
        idle_check();
        send(4'd0, 8'h01, 12'hFAA, 8'h80);   // R5 flip 0->1
        send(4'd0, 8'h01, 12'hFAA, 8'hC0);   // R5 same bit, no pulse
        send(4'd0, 8'h01, 12'hFAA, 8'h40);   // R5 flip 1->0
        send(4'd0, 8'h01, 12'hFAF, 8'h80);   // R5 register 1 no pulse
        send(4'd0, 8'h01, 12'hF80, 8'h01);   // R7 ignored
        send(4'd0, 8'h04, 12'hFA7, 8'hAA);   // R4 wrong node
        send(4'd3, 8'h01, 12'hFA7, 8'hAA);   // R4 wrong codec
        send(4'd0, 8'h01, 12'hFA7, 8'h34);   // R3
        send(4'd0, 8'h01, 12'hFA8, 8'h12);   // R3
        send(4'd0, 8'h01, 12'hFA6, 8'h00);   // R2 expect 0x40001234
        send(4'd0, 8'h01, 12'h123, 8'h55);   // R8
        send(4'd0, 8'h01, 12'hFAB, 8'h00);   // R2
        random_run(300);
        // ---------------- newer mode ----------------
        do_reset(1'b1);
        send(4'd0, 8'h04, 12'hFA6, 8'h00);   // R9
        send(4'd0, 8'h04, 12'hFAA, 8'h80);   // R6 trigger bit silent
        send(4'd0, 8'h04, 12'hF80, 8'h00);   // R6 zero payload silent
        send(4'd0, 8'h04, 12'hF80, 8'h05);   // R6 pulse
        send(4'd0, 8'h01, 12'hF80, 8'h05);   // R4 legacy node rejected
        send(4'd0, 8'h01, 12'hFAD, 8'h77);   // R4
        send(4'd0, 8'h04, 12'hFAB, 8'h00);   // R2
        random_run(300);
        idle_check();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule